// File: doc/BRIEF.md
# Token-Chained Event FIFO Drain Serializer

This block empties a set of per-chip event FIFOs onto one narrow output bus, one FIFO after another. Each chip has its own 64-bit FIFO and its own drain stage. The stages are linked in a token chain. The event trigger hands the token to stage 0. A stage that holds the token reads its FIFO until the FIFO is empty, and then passes the token to the next stage by pulsing its done line.

Each stored word is cut into four 16-bit beats, most significant beat first. Before the word is sent, its top three bits are replaced with the number of the chip that supplied it, so the receiver can tell the chips apart in the merged stream. A registered multiplexer puts the beat of the active stage on the output bus and raises `beat_valid` for that beat. After the last stage passes its token, the block raises an `event_end` pulse. The block sits in front of a serial optical link transmitter. The FIFOs are filled through one write port per chip, on the same clock.

Top module: `fifo_chain_drain`

## Requirements
- R1: After reset, `beat_valid`, `event_end` and every `fifo_full` bit are low.
- R2: An event sends the stored words of chip 0 first, then chip 1, and so on up to chip 7. Within each chip, words go out in the order they were written.
- R3: Each stored word produces exactly four beats, most significant first. Beat n carries word bits [63-16n : 48-16n].
- R4: In the first beat of every word, bits [15:13] (word bits [63:61]) hold the source chip number. The other 61 bits of the word are passed through unchanged.
- R5: A stage whose FIFO is empty when it gets the token sends no beats and passes the token on the next cycle. An event in which every FIFO is empty raises `event_end` within 12 cycles of the trigger and sends no beats.
- R6: At most one stage drives the output in any cycle. `beat_valid` is high for each beat sent and for nothing else.
- R7: `event_end` is a one-cycle pulse, raised exactly once per event after the last beat. No beat is valid in the same cycle.
- R8: A trigger that arrives while an event is still draining is ignored. A word written into an already-drained FIFO during the event waits for the next trigger.
- R9: `fifo_full[k]` is high when FIFO k holds DEPTH words. A write to a full FIFO is dropped.
- R10: A drain stage never reads from an empty FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| trig | input | 1 | Event trigger; hands the token to stage 0 when no event is in progress |
| wr_en | input | NCHIP | Per-chip FIFO write enable |
| wr_data | input | NCHIP*WORD_W | Per-chip write words; chip k uses bits [k*WORD_W +: WORD_W] |
| fifo_full | output | NCHIP | Per-chip FIFO full flag |
| beat_data | output | BEAT_W | Output beat |
| beat_valid | output | 1 | High when `beat_data` carries a beat |
| event_end | output | 1 | One-cycle pulse after the last stage passes the token |

## Verification
The bench goes after these corner cases:
- An empty chip 0 ahead of loaded chips, and a chain with every FIFO empty. A stage that stalls or emits a stray word here would either lose the token or add beats.
- Every FIFO filled to DEPTH, with one extra write into a full FIFO. A design that wraps its pointers would send a 17th word or lose 16.
- Words loaded into a high chip before a low chip. This catches designs that send in write order rather than chip order.
- A second trigger, plus a fresh word for chip 0, in the middle of a drain. A design that honours the trigger would send that word twice, or send it out of order, and would raise `event_end` an extra time.

Each event's data puts ones in the top bits of the stored words, so a missing or misplaced chip number shows up in the first beat of every word.

// File: rtl/drain_pkg.sv
package drain_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_SEND
  } drain_state_e;

endpackage

// File: rtl/drain_fifo.sv
module drain_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr, rptr;
  logic         do_wr, do_rd;

  assign empty = (wptr == rptr);
  assign full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (do_rd) rd_data <= mem[rptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) rptr <= rptr + 1'b1;
    end
  end

endmodule

// File: rtl/drain_stage.sv
module drain_stage
  import drain_pkg::*;
#(
  parameter int WORD_W  = 64,
  parameter int BEAT_W  = 16,
  parameter int ID_W    = 3,
  parameter int CHIP_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_data,
  output logic              fifo_rd,
  output logic [BEAT_W-1:0] beat_data,
  output logic              beat_vld,
  output logic              done
);
  localparam int BEATS = WORD_W / BEAT_W;
  localparam int IW    = $clog2(BEATS);

  drain_state_e      state;
  logic [IW-1:0]     beat_idx;
  logic [WORD_W-1:0] shreg;

  assign fifo_rd   = (state == ST_FETCH);
  assign beat_vld  = (state == ST_SEND);
  assign beat_data = shreg[WORD_W-1 -: BEAT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      beat_idx <= '0;
      shreg    <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (fifo_empty) done  <= 1'b1;
            else            state <= ST_FETCH;
          end
        end
        ST_FETCH: state <= ST_LOAD;
        ST_LOAD: begin
          shreg                     <= fifo_data;
          shreg[WORD_W-1 -: ID_W]   <= ID_W'(CHIP_ID);
          beat_idx                  <= '0;
          state                     <= ST_SEND;
        end
        ST_SEND: begin
          shreg    <= {shreg[WORD_W-BEAT_W-1:0], {BEAT_W{1'b0}}};
          beat_idx <= beat_idx + 1'b1;
          if (beat_idx == IW'(BEATS-1)) begin
            if (fifo_empty) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              state <= ST_FETCH;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/beat_mux.sv
module beat_mux #(
  parameter int NCHIP  = 8,
  parameter int BEAT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NCHIP-1:0]        in_vld,
  input  logic [NCHIP*BEAT_W-1:0] in_data,
  output logic [BEAT_W-1:0]       out_data,
  output logic                    out_vld
);
  logic [BEAT_W-1:0] sel_data;

  // AND-OR select: the token guarantees one active stage
  always_comb begin
    sel_data = '0;
    for (int k = 0; k < NCHIP; k++) begin
      sel_data = sel_data | (in_data[k*BEAT_W +: BEAT_W] & {BEAT_W{in_vld[k]}});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data <= '0;
      out_vld  <= 1'b0;
    end else begin
      out_data <= sel_data;
      out_vld  <= |in_vld;
    end
  end

endmodule

// File: rtl/fifo_chain_drain.sv
module fifo_chain_drain #(
  parameter int NCHIP  = 8,
  parameter int WORD_W = 64,
  parameter int BEAT_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    trig,
  input  logic [NCHIP-1:0]        wr_en,
  input  logic [NCHIP*WORD_W-1:0] wr_data,
  output logic [NCHIP-1:0]        fifo_full,
  output logic [BEAT_W-1:0]       beat_data,
  output logic                    beat_valid,
  output logic                    event_end
);
  localparam int ID_W  = $clog2(NCHIP);
  localparam int BEATS = WORD_W / BEAT_W;

  logic [NCHIP-1:0]        stage_vld, stage_done, stage_start;
  logic [NCHIP-1:0]        fifo_rd, fifo_empty;
  logic [NCHIP*BEAT_W-1:0] stage_beats;
  logic [WORD_W-1:0]       rd_word [NCHIP];
  logic                    busy, kick;

  // event control: one event at a time
  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      kick      <= 1'b0;
      event_end <= 1'b0;
    end else begin
      kick      <= trig && !busy;
      event_end <= stage_done[NCHIP-1];
      if (trig && !busy) busy <= 1'b1;
      else if (event_end) busy <= 1'b0;
    end
  end

  assign stage_start[0] = kick;

  for (genvar k = 0; k < NCHIP; k++) begin : g_chip
    if (k > 0) begin : g_link
      assign stage_start[k] = stage_done[k-1];
    end

    drain_fifo #(
      .W     (WORD_W),
      .DEPTH (DEPTH)
    ) fifo_i (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en[k]),
      .wr_data (wr_data[k*WORD_W +: WORD_W]),
      .rd_en   (fifo_rd[k]),
      .rd_data (rd_word[k]),
      .empty   (fifo_empty[k]),
      .full    (fifo_full[k])
    );

    drain_stage #(
      .WORD_W  (WORD_W),
      .BEAT_W  (BEAT_W),
      .ID_W    (ID_W),
      .CHIP_ID (k)
    ) stage_i (
      .clk        (clk),
      .rst        (rst),
      .start      (stage_start[k]),
      .fifo_empty (fifo_empty[k]),
      .fifo_data  (rd_word[k]),
      .fifo_rd    (fifo_rd[k]),
      .beat_data  (stage_beats[k*BEAT_W +: BEAT_W]),
      .beat_vld   (stage_vld[k]),
      .done       (stage_done[k])
    );
  end

  beat_mux #(
    .NCHIP  (NCHIP),
    .BEAT_W (BEAT_W)
  ) mux_i (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (stage_vld),
    .in_data  (stage_beats),
    .out_data (beat_data),
    .out_vld  (beat_valid)
  );

endmodule

// File: rtl/fifo_chain_drain_chk.sv
module fifo_chain_drain_chk #(
  parameter int NCHIP = 8,
  parameter int ID_W  = 3,
  parameter int BEATS = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [NCHIP-1:0] stage_vld,
  input logic [NCHIP-1:0] stage_done,
  input logic [NCHIP-1:0] fifo_rd,
  input logic [NCHIP-1:0] fifo_empty,
  input logic             beat_valid,
  input logic [ID_W-1:0]  tag_bits,
  input logic             event_end
);
  localparam int PW = $clog2(BEATS);

  logic [ID_W-1:0] cur_idx, prev_idx;
  logic [PW-1:0]   phase;

  always_comb begin
    cur_idx = '0;
    for (int k = 0; k < NCHIP; k++) begin
      if (stage_vld[k]) cur_idx = ID_W'(k);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_idx <= '0;
      phase    <= '0;
    end else begin
      prev_idx <= cur_idx;
      if (beat_valid) phase <= (phase == PW'(BEATS-1)) ? '0 : phase + 1'b1;
    end
  end

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst) $onehot0(stage_vld)); // R6
  AST_TOKEN_SINGLE: assert property (@(posedge clk) disable iff (rst) $onehot0(stage_done)); // R2
  AST_NO_EMPTY_READ: assert property (@(posedge clk) disable iff (rst) (fifo_rd & fifo_empty) == '0); // R10
  AST_CHIP_TAG: assert property (@(posedge clk) disable iff (rst) (beat_valid && phase == '0) |-> tag_bits == prev_idx); // R4
  AST_END_NO_BEAT: assert property (@(posedge clk) disable iff (rst) event_end |-> !beat_valid); // R7
  AST_END_PULSE: assert property (@(posedge clk) disable iff (rst) event_end |=> !event_end); // R7

endmodule

bind fifo_chain_drain fifo_chain_drain_chk #(
  .NCHIP (NCHIP),
  .ID_W  (ID_W),
  .BEATS (BEATS)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .stage_vld  (stage_vld),
  .stage_done (stage_done),
  .fifo_rd    (fifo_rd),
  .fifo_empty (fifo_empty),
  .beat_valid (beat_valid),
  .tag_bits   (beat_data[BEAT_W-1 -: ID_W]),
  .event_end  (event_end)
);

// File: tb/fifo_chain_drain_tb_top.sv
module fifo_chain_drain_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCHIP  = 8;
  localparam int WORD_W = 64;
  localparam int BEAT_W = 16;
  localparam int DEPTH  = 16;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    trig = 1'b0;
  logic [NCHIP-1:0]        wr_en = '0;
  logic [NCHIP*WORD_W-1:0] wr_data = '0;
  logic [NCHIP-1:0]        fifo_full;
  logic [BEAT_W-1:0]       beat_data;
  logic                    beat_valid;
  logic                    event_end;

  fifo_chain_drain #(
    .NCHIP(NCHIP), .WORD_W(WORD_W), .BEAT_W(BEAT_W), .DEPTH(DEPTH)
  ) dut_i (
    .clk(clk), .rst(rst), .trig(trig), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_full(fifo_full), .beat_data(beat_data), .beat_valid(beat_valid),
    .event_end(event_end)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int got_n  = 0;
  int exp_n  = 0;
  int ev_cnt = 0;
  bit finished = 0;
  logic [BEAT_W-1:0] got  [4096];
  logic [BEAT_W-1:0] expb [4096];
  int cnt [NCHIP];

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (beat_valid) begin
        got[got_n] = beat_data;
        got_n++;
      end
      if (event_end) ev_cnt++;
    end
    if (cyc > 150000 && !finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual cycles %0d expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exv);
    end
  endtask

  function automatic logic [63:0] gen(input int c, input int i, input logic [7:0] ev);
    return {ev, 8'(c), 16'(i), 16'hC0DE, 8'(c*16 + i), ev ^ 8'h3C};
  endfunction

  // expected beats: chain order, chip number in bits [63:61], MSB beat first
  task automatic push_word(input int c, input logic [63:0] w);
    logic [63:0] t;
    t = {3'(c), w[60:0]};
    for (int b = 0; b < 4; b++) begin
      expb[exp_n] = t[63 - 16*b -: 16];
      exp_n++;
    end
  endtask

  task automatic build_exp(input logic [7:0] ev);
    for (int c = 0; c < NCHIP; c++)
      for (int i = 0; i < cnt[c]; i++) push_word(c, gen(c, i, ev));
  endtask

  task automatic load(input int c, input int n, input logic [7:0] ev);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = '0;
      wr_en[c] = 1'b1;
      wr_data[c*WORD_W +: WORD_W] = gen(c, i, ev);
    end
    @(negedge clk);
    wr_en = '0;
  endtask

  task automatic pulse_trig();
    @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic wait_end(input int e0, output int lat);
    lat = 1;
    while (ev_cnt == e0 && lat < 6000) begin
      @(negedge clk);
      #1;
      lat++;
    end
    repeat (6) @(negedge clk);
    #1;
  endtask

  task automatic cmp(input string req, input int gb, input int eb, input int n);
    int mism;
    int first;
    mism = 0;
    first = -1;
    check(got_n - gb == n, {req, " beat count"}, got_n - gb, n);
    for (int i = 0; i < n; i++) begin
      if (got[gb + i] !== expb[eb + i]) begin
        mism++;
        if (first < 0) first = i;
      end
    end
    if (first < 0) first = 0;
    check(mism == 0, {req, " beat content"}, got[gb + first], expb[eb + first]);
  endtask

  task automatic run_event(input string req, input logic [7:0] ev);
    int gb, eb, e0, lat;
    gb = got_n; eb = exp_n; e0 = ev_cnt;
    build_exp(ev);
    pulse_trig();
    wait_end(e0, lat);
    cmp(req, gb, eb, exp_n - eb);
    check(ev_cnt - e0 == 1, {req, " R7 event_end count"}, ev_cnt - e0, 1);
  endtask

  initial begin
    int gb, eb, e0, lat;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check(beat_valid == 1'b0, "R1 beat_valid after reset", beat_valid, 0);
    check(event_end == 1'b0, "R1 event_end after reset", event_end, 0);
    check(fifo_full == '0, "R1 fifo_full after reset", fifo_full, 0);

    // chip k holds k words; chip 0 empty (R2 R3 R4 R5)
    for (int c = 0; c < NCHIP; c++) begin
      cnt[c] = c;
      load(c, c, 8'hA5);
    end
    run_event("R2 R3 R4 ramp", 8'hA5);

    // every FIFO empty (R5)
    for (int c = 0; c < NCHIP; c++) cnt[c] = 0;
    gb = got_n; e0 = ev_cnt;
    pulse_trig();
    wait_end(e0, lat);
    check(got_n - gb == 0, "R5 all-empty beat count", got_n - gb, 0);
    check(lat <= 12, "R5 all-empty latency", lat, 12);
    check(ev_cnt - e0 == 1, "R7 all-empty event_end count", ev_cnt - e0, 1);

    // fill every FIFO, one extra write into chip 3 (R9)
    for (int c = 0; c < NCHIP; c++) begin
      cnt[c] = DEPTH;
      load(c, (c == 3) ? DEPTH + 1 : DEPTH, 8'hFF);
    end
    #1;
    check(fifo_full == '1, "R9 full flags", fifo_full, 8'hFF);
    run_event("R9 R3 full drain", 8'hFF);
    check(fifo_full == '0, "R9 full flags cleared", fifo_full, 0);

    // load high chip before low chip (R2 order)
    for (int c = 0; c < NCHIP; c++) cnt[c] = 0;
    cnt[7] = 3; cnt[2] = 1;
    load(7, 3, 8'hE7);
    load(2, 1, 8'hE7);
    run_event("R2 chip order", 8'hE7);

    // second trigger mid-drain plus late word for chip 0 (R8)
    for (int c = 0; c < NCHIP; c++) begin
      cnt[c] = 2;
      load(c, 2, 8'hC3);
    end
    gb = got_n; eb = exp_n; e0 = ev_cnt;
    build_exp(8'hC3);
    pulse_trig();
    repeat (40) @(negedge clk);
    load(0, 1, 8'h9E);
    pulse_trig();
    wait_end(e0, lat);
    cmp("R8 ignored trigger", gb, eb, exp_n - eb);
    check(ev_cnt - e0 == 1, "R8 single event_end", ev_cnt - e0, 1);
    for (int c = 0; c < NCHIP; c++) cnt[c] = 0;
    cnt[0] = 1;
    run_event("R8 late word next event", 8'h9E);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule